// File: doc/BRIEF.md
# Buffered Period/Compare Timer Core

A 16-bit up or up/down counter that advances on a divided clock enable and compares its count against an active period (TOP) and an active compare value. It produces a waveform bit and two sticky event flags. The counter can wrap from TOP to zero (single-slope) or climb to TOP and descend back to zero (dual-slope). Software never writes the active period or compare value directly. It writes a shadow (buffer) register, whose pending flag marks it as waiting. The shadow is copied into the active register at a point in the count where the change cannot cause a glitch, or at once when an update command is given.

Software may also load the count directly, restart the counter and clear the flags. A direct count load always wins over any other change to the count. All inputs are plain control pins: each write strobe is taken in the cycle it is high, with no handshake and no back-pressure. The block can always accept a write.

Top module: `tmr_core`

## Requirements
- R1: After reset the count is 0, the active period is 0xFFFF, the active compare value is 0, the direction bit is 0 (up), and both pending bits, both flags and the waveform are 0.
- R2: clk_sel encodes 0 = stopped, 1..7 = divide by 1, 2, 4, 8, 64, 256, 1024. A prescaler cleared by restart counts clock cycles while clk_sel is nonzero and holds while it is 0. With divide ratio d, a count step happens in every d-th running cycle.
- R3: With dual_slope = 0, each count step adds 1. A step taken at count == period goes to 0 instead.
- R4: With dual_slope = 1, the count rises by 1 per step until it equals the period. The next step sets dir_down = 1 and keeps the count. The count then falls by 1 per step until it reaches 0, and the next step clears dir_down and keeps the count at 0.
- R5: A write strobe to the period or compare shadow sets its pending bit and does not change the active value.
- R6: A pending shadow is copied into its active register on the wrap step (single-slope) or on the step taken at 0 while descending (dual-slope), and its pending bit then clears.
- R7: cmd_update copies every pending shadow into its active register at the next edge. A shadow that is not pending leaves its active value unchanged.
- R8: cmd_restart zeroes the count, the direction bit, the waveform and the prescaler.
- R9: A count load with cnt_wr_en places cnt_wr_data into the count at the next edge. It overrides a count step and a restart in that same cycle.
- R10: ovf_flag sets on every wrap step (R3) and on every step at 0 while descending (R4). A pulse on ovf_clr clears it, but a set in the same cycle wins.
- R11: cmp_flag sets on a step taken while count == compare, and cmp_clr clears it, with a set winning. The waveform rules are as follows. Single-slope: a wrap step drives the waveform to 1, and otherwise a compare step drives it to 0. Dual-slope: a compare step drives it to 0 while rising and to 1 while descending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Step rate select (R2 encoding) |
| dual_slope | input | 1 | 0 single-slope, 1 dual-slope |
| per_wr_en | input | 1 | Period shadow write strobe |
| per_wr_data | input | 16 | Period shadow data |
| cmp_wr_en | input | 1 | Compare shadow write strobe |
| cmp_wr_data | input | 16 | Compare shadow data |
| cnt_wr_en | input | 1 | Direct count load strobe |
| cnt_wr_data | input | 16 | Direct count load value |
| cmd_update | input | 1 | Copy pending shadows now |
| cmd_restart | input | 1 | Restart counter |
| ovf_clr | input | 1 | Clear overflow flag |
| cmp_clr | input | 1 | Clear compare flag |
| cnt | output | 16 | Current count |
| per | output | 16 | Active period |
| cmp | output | 16 | Active compare value |
| per_pending | output | 1 | Period shadow pending |
| cmp_pending | output | 1 | Compare shadow pending |
| dir_down | output | 1 | Counting downward |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The properties assume that reset is applied before the first edge and that every strobe input has a defined value in every cycle. They make no assumption about how strobes overlap, so a load together with a restart, or a shadow write during a copy, are both legal. The bench drives all strobes on the falling edge as single-cycle pulses. When it wants predictable step counts, it stops the prescaler (clk_sel = 0) before it rewrites the shadows. Overlaps are still exercised on purpose: a load with a restart, a load with a step, and a flag clear with a flag set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_OFF    = 3'd0,
    CS_DIV1   = 3'd1,
    CS_DIV2   = 3'd2,
    CS_DIV4   = 3'd3,
    CS_DIV8   = 3'd4,
    CS_DIV64  = 3'd5,
    CS_DIV256 = 3'd6,
    CS_DIV1024 = 3'd7
  } clk_sel_e;

  // log2 of the divide ratio for each select code
  function automatic logic [3:0] div_shift(clk_sel_e sel);
    case (sel)
      CS_DIV2:    div_shift = 4'd1;
      CS_DIV4:    div_shift = 4'd2;
      CS_DIV8:    div_shift = 4'd3;
      CS_DIV64:   div_shift = 4'd6;
      CS_DIV256:  div_shift = 4'd8;
      CS_DIV1024: div_shift = 4'd10;
      default:    div_shift = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tmr_pkg::clk_sel_e   sel,
  input  logic                restart,
  output logic                tick
);
  import tmr_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   full_mask;
  logic [PRE_W-1:0] mask;
  logic             running;

  assign running   = (sel != CS_OFF);
  assign full_mask = ({{PRE_W{1'b0}}, 1'b1} << div_shift(sel)) - 1'b1;
  assign mask      = full_mask[PRE_W-1:0];
  assign tick      = running && ((pre_cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (restart) pre_cnt <= '0;
    else if (running) pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         copy,
  output logic [W-1:0] active,
  output logic         pending
);
  logic [W-1:0] shadow;
  logic         take;

  assign take = copy && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      active  <= RST_VAL;
      pending <= 1'b0;
    end else begin
      if (take)  active <= shadow;
      if (wr_en) shadow <= wr_data;
      if (wr_en)     pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dual,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] cmp,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             wave,
  output logic             wrap_evt,
  output logic             hit_evt
);
  logic             step;
  logic             at_top, at_bot, hit;
  logic [CNT_W-1:0] cnt_nx;
  logic             dir_nx, wrap_nx, wave_nx;

  assign at_top = (cnt == per);
  assign at_bot = (cnt == '0);
  assign hit    = (cnt == cmp);
  assign step   = tick && !load_en && !restart;

  always_comb begin
    cnt_nx  = cnt;
    dir_nx  = dir_down;
    wrap_nx = 1'b0;
    if (!dual) begin
      dir_nx = 1'b0;
      if (at_top) begin
        cnt_nx  = '0;
        wrap_nx = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else if (!dir_down) begin
      if (at_top) dir_nx = 1'b1;
      else        cnt_nx = cnt + 1'b1;
    end else begin
      if (at_bot) begin
        dir_nx  = 1'b0;
        wrap_nx = 1'b1;
      end else begin
        cnt_nx = cnt - 1'b1;
      end
    end
  end

  always_comb begin
    wave_nx = wave;
    if (!dual) begin
      if (wrap_nx)  wave_nx = 1'b1;
      else if (hit) wave_nx = 1'b0;
    end else if (hit) begin
      wave_nx = dir_down;
    end
  end

  assign wrap_evt = step && wrap_nx;
  assign hit_evt  = step && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      wave     <= 1'b0;
    end else begin
      if (load_en)      cnt <= load_val;
      else if (restart) cnt <= '0;
      else if (step)    cnt <= cnt_nx;

      if (restart) begin
        dir_down <= 1'b0;
        wave     <= 1'b0;
      end else if (step) begin
        dir_down <= dir_nx;
        wave     <= wave_nx;
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             dual_slope,
  input  logic             per_wr_en,
  input  logic [CNT_W-1:0] per_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmd_update,
  input  logic             cmd_restart,
  input  logic             ovf_clr,
  input  logic             cmp_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cmp,
  output logic             per_pending,
  output logic             cmp_pending,
  output logic             dir_down,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] PER_RST = {CNT_W{1'b1}};
  localparam int               NBUF    = 2;

  logic             tick;
  logic             wrap_evt, hit_evt, copy;
  logic [NBUF-1:0]  sh_wr;
  logic [CNT_W-1:0] sh_data [NBUF];
  logic [CNT_W-1:0] sh_act  [NBUF];
  logic [NBUF-1:0]  sh_pend;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel_e'(clk_sel)),
    .restart (cmd_restart),
    .tick    (tick)
  );

  assign copy       = cmd_update || wrap_evt;
  assign sh_wr      = {cmp_wr_en, per_wr_en};
  assign sh_data[0] = per_wr_data;
  assign sh_data[1] = cmp_wr_data;

  for (genvar g = 0; g < NBUF; g++) begin : g_shadow
    tmr_shadow #(
      .W       (CNT_W),
      .RST_VAL ((g == 0) ? PER_RST : {CNT_W{1'b0}})
    ) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sh_wr[g]),
      .wr_data (sh_data[g]),
      .copy    (copy),
      .active  (sh_act[g]),
      .pending (sh_pend[g])
    );
  end

  assign per         = sh_act[0];
  assign cmp         = sh_act[1];
  assign per_pending = sh_pend[0];
  assign cmp_pending = sh_pend[1];

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .dual     (dual_slope),
    .per      (per),
    .cmp      (cmp),
    .load_en  (cnt_wr_en),
    .load_val (cnt_wr_data),
    .restart  (cmd_restart),
    .cnt      (cnt),
    .dir_down (dir_down),
    .wave     (wave_out),
    .wrap_evt (wrap_evt),
    .hit_evt  (hit_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (wrap_evt)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (hit_evt)      cmp_flag <= 1'b1;
      else if (cmp_clr) cmp_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             cmd_restart,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_down,
  input logic             wave_out,
  input logic             per_wr_en,
  input logic             per_pending,
  input logic [CNT_W-1:0] per,
  input logic             ovf_flag,
  input logic             ovf_clr
);
  // R2: without a step, load or restart the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr_en && !cmd_restart) |=> $stable(cnt));

  // R9: a load lands next cycle whatever else is asserted
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt == $past(cnt_wr_data)));

  // R8: restart zeroes direction and waveform, and the count unless loaded
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_restart && !cnt_wr_en) |=> (cnt == '0 && !dir_down && !wave_out));

  // R5: a shadow write always leaves the shadow pending
  p_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |=> per_pending);

  // R6: active period changes only out of a pending shadow
  p_per_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !per_pending |=> $stable(per));

  // R10: overflow flag is sticky until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cmd_restart (cmd_restart),
  .cnt         (cnt),
  .dir_down    (dir_down),
  .wave_out    (wave_out),
  .per_wr_en   (per_wr_en),
  .per_pending (per_pending),
  .per         (per),
  .ovf_flag    (ovf_flag),
  .ovf_clr     (ovf_clr)
);

// File: tb/test_tmr_core.sv
module test_tmr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic        dual_slope = 1'b0;
  logic        per_wr_en = 1'b0, cmp_wr_en = 1'b0, cnt_wr_en = 1'b0;
  logic [15:0] per_wr_data = '0, cmp_wr_data = '0, cnt_wr_data = '0;
  logic        cmd_update = 1'b0, cmd_restart = 1'b0, ovf_clr = 1'b0, cmp_clr = 1'b0;
  logic [15:0] cnt, per, cmp;
  logic        per_pending, cmp_pending, dir_down, wave_out, ovf_flag, cmp_flag;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tmr_core i_tmr_core (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .dual_slope(dual_slope),
    .per_wr_en(per_wr_en), .per_wr_data(per_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmd_update(cmd_update), .cmd_restart(cmd_restart),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
    .cnt(cnt), .per(per), .cmp(cmp),
    .per_pending(per_pending), .cmp_pending(cmp_pending),
    .dir_down(dir_down), .wave_out(wave_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  typedef struct packed {
    logic        dual;
    logic [15:0] per;
    logic [15:0] cmp;
    logic [2:0]  sel;
    logic [15:0] ncyc;
    logic [15:0] e_cnt;
    logic        e_dir;
    logic        e_ovf;
    logic        e_wave;
  } vec_t;

  // R3/R4/R2/R11 scenarios, expected values worked out by hand
  localparam vec_t VECS [9] = '{
    '{1'b0, 16'd9, 16'd4, 3'd1, 16'd7,   16'd7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd9, 16'd4, 3'd1, 16'd12,  16'd2, 1'b0, 1'b1, 1'b1},
    '{1'b0, 16'd9, 16'd4, 3'd3, 16'd30,  16'd7, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'd5, 16'd2, 3'd1, 16'd8,   16'd3, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd5, 16'd2, 3'd2, 16'd26,  16'd1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 16'd0, 16'd0, 3'd4, 16'd20,  16'd0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 16'd3, 16'd1, 3'd5, 16'd300, 16'd0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 16'd3, 16'd1, 3'd0, 16'd20,  16'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'd2, 16'd2, 3'd1, 16'd5,   16'd0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic dual, input logic [15:0] p, input logic [15:0] c);
    @(negedge clk);
    clk_sel = 3'd0; dual_slope = dual;
    per_wr_en = 1'b1; per_wr_data = p; cmp_wr_en = 1'b1; cmp_wr_data = c;
    @(negedge clk);
    per_wr_en = 1'b0; cmp_wr_en = 1'b0; cmd_update = 1'b1;
    @(negedge clk);
    cmd_update = 1'b0; cmd_restart = 1'b1; ovf_clr = 1'b1; cmp_clr = 1'b1;
    @(negedge clk);
    cmd_restart = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
  endtask

  // sel applied for n rising edges, then stopped; called on a falling edge
  task automatic run(input logic [2:0] sel, input int n);
    clk_sel = sel;
    repeat (n) @(negedge clk);
    clk_sel = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cnt", cnt, 16'h0);
    check("R1", "per", per, 16'hFFFF);
    check("R1", "cmp", cmp, 16'h0);
    check("R1", "pending", {14'd0, per_pending, cmp_pending}, 16'h0);
    check("R1", "flags", {13'd0, ovf_flag, cmp_flag, wave_out}, 16'h0);
    check("R1", "dir", {15'd0, dir_down}, 16'h0);

    for (int i = 0; i < 9; i++) begin
      setup(VECS[i].dual, VECS[i].per, VECS[i].cmp);
      run(VECS[i].sel, int'(VECS[i].ncyc));
      check("R3/R4/R2", $sformatf("vec%0d cnt", i), cnt, VECS[i].e_cnt);
      check("R4", $sformatf("vec%0d dir", i), {15'd0, dir_down}, {15'd0, VECS[i].e_dir});
      check("R10", $sformatf("vec%0d ovf", i), {15'd0, ovf_flag}, {15'd0, VECS[i].e_ovf});
      check("R11", $sformatf("vec%0d wave", i), {15'd0, wave_out}, {15'd0, VECS[i].e_wave});
    end

    // R5/R6 single-slope: shadow waits for the wrap
    setup(1'b0, 16'd5, 16'd3);
    per_wr_en = 1'b1; per_wr_data = 16'd2;
    @(negedge clk); per_wr_en = 1'b0;
    check("R5", "per held", per, 16'd5);
    check("R5", "per pending", {15'd0, per_pending}, 16'd1);
    cnt_wr_en = 1'b1; cnt_wr_data = 16'd5;
    @(negedge clk); cnt_wr_en = 1'b0;
    run(3'd1, 1);
    check("R6", "per after wrap", per, 16'd2);
    check("R6", "pending cleared", {15'd0, per_pending}, 16'd0);
    check("R3", "cnt after wrap", cnt, 16'd0);

    // R6 dual-slope: copy only on the bottom step while descending
    setup(1'b1, 16'd1, 16'd0);
    cmp_wr_en = 1'b1; cmp_wr_data = 16'd7;
    @(negedge clk); cmp_wr_en = 1'b0;
    run(3'd1, 3);
    check("R6", "cmp held before bottom", cmp, 16'd0);
    check("R5", "cmp pending", {15'd0, cmp_pending}, 16'd1);
    run(3'd1, 1);
    check("R6", "cmp at bottom", cmp, 16'd7);
    check("R6", "cmp pending cleared", {15'd0, cmp_pending}, 16'd0);

    // R7 update copies only pending shadows
    setup(1'b0, 16'd10, 16'd10);
    per_wr_en = 1'b1; per_wr_data = 16'd20;
    @(negedge clk); per_wr_en = 1'b0; cmd_update = 1'b1;
    @(negedge clk); cmd_update = 1'b0;
    check("R7", "per updated", per, 16'd20);
    check("R7", "cmp untouched", cmp, 16'd10);

    // R9 load beats step and restart
    setup(1'b0, 16'h40, 16'd0);
    clk_sel = 3'd1; cnt_wr_en = 1'b1; cnt_wr_data = 16'h20;
    @(negedge clk); cnt_wr_en = 1'b0;
    check("R9", "load over step", cnt, 16'h20);
    @(negedge clk); clk_sel = 3'd0;
    check("R3", "step after load", cnt, 16'h21);
    cnt_wr_en = 1'b1; cnt_wr_data = 16'h33; cmd_restart = 1'b1;
    @(negedge clk); cnt_wr_en = 1'b0; cmd_restart = 1'b0;
    check("R9", "load over restart", cnt, 16'h33);

    // R4 then R8
    setup(1'b1, 16'd3, 16'd9);
    run(3'd1, 6);
    check("R4", "descending cnt", cnt, 16'd1);
    check("R4", "descending dir", {15'd0, dir_down}, 16'd1);
    cmd_restart = 1'b1;
    @(negedge clk); cmd_restart = 1'b0;
    check("R8", "restart cnt", cnt, 16'd0);
    check("R8", "restart dir", {15'd0, dir_down}, 16'd0);

    // R10 set beats clear, clear alone works
    setup(1'b0, 16'd0, 16'd5);
    run(3'd1, 4);
    clk_sel = 3'd1; ovf_clr = 1'b1;
    @(negedge clk); clk_sel = 3'd0;
    check("R10", "set wins over clear", {15'd0, ovf_flag}, 16'd1);
    @(negedge clk); ovf_clr = 1'b0;
    check("R10", "clear", {15'd0, ovf_flag}, 16'd0);

    // R11 compare flag
    setup(1'b0, 16'd9, 16'd4);
    run(3'd1, 4);
    check("R11", "no match yet", {15'd0, cmp_flag}, 16'd0);
    run(3'd1, 1);
    check("R11", "match flag", {15'd0, cmp_flag}, 16'd1);
    cmp_clr = 1'b1;
    @(negedge clk); cmp_clr = 1'b0;
    check("R11", "match clear", {15'd0, cmp_flag}, 16'd0);

    // R2 divide by 1024
    setup(1'b0, 16'hFFFF, 16'hFFFF);
    run(3'd7, 1023);
    check("R2", "div1024 before step", cnt, 16'd0);
    run(3'd7, 1);
    check("R2", "div1024 step", cnt, 16'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule